// File: doc/BRIEF.md
# I2C Master Status Flag Unit

This block holds the eight-bit status word of an I2C master channel. The master engine reports its condition through event pulses and level signals: busy, arbitration lost, address not acknowledged, byte received, transfer finished, transmit FIFO underflow and transmit FIFO empty. The unit turns these into sticky flags. Each flag has its own set source and its own clear trigger. Several flags are cleared as a side effect of host accesses to the data ports rather than by writes to the status word.

The host reads the word through `status`. It can request a transmit FIFO flush by writing the status word with bit 7 set. A small state machine, with states FL_IDLE and FL_FLUSH, handles the flush:
- A host write with bit 7 set, made while in FL_IDLE, causes the transition FL_IDLE→FL_FLUSH.
- While in FL_FLUSH, the unit asserts flush requests to the master transmit FIFO and to the slave receive FIFO.
- A `flush_done` pulse causes the transition FL_FLUSH→FL_IDLE.
- In every other case the machine stays in its present state.

The combined `irq` line is asserted whenever any of four flags is set: receive, transmit, no-ACK or arbitration lost.

Top module: `i2cm_status`

## Requirements
- R1: After reset, `status` reads 0x01, with only TX-empty set. `flush_master_tx`, `flush_slave_rx` and `irq` are low.
- R2: A status write with `sts_wdata[7]`=1, made while no flush is in progress, sets `status[7]`, `flush_master_tx` and `flush_slave_rx` one cycle later. All three stay high until the cycle after a `flush_done` pulse. A `flush_done` pulse while no flush is in progress has no effect.
- R3: A status write with `sts_wdata[7]`=0 changes no status bit, whatever the other data bits are.
- R4: `status[6]` (busy) equals `eng_busy` as it was on the previous clock edge.
- R5: `status[5]` (arbitration lost) is set by an `eng_arb_lost` pulse. Host accesses do not clear it. It clears in the cycle after `bus_idle` is high.
- R6: `status[4]` (no-ACK) is set by `eng_addr_nack` and cleared by a status read (`sts_rd`).
- R7: `status[3]` (receive IRQ) is set by `eng_rx_byte` and cleared by a receive-port read (`rxd_rd`).
- R8: `status[2]` (transmit IRQ) is set by `eng_tx_done`, and `status[1]` (underflow) is set by `txf_underflow`. Both are cleared by a transmit-port write (`txd_wr`).
- R9: `status[0]` (TX empty) is set by a rising edge of `txf_empty` and cleared by `txd_wr`.
- R10: When a set event and its clearing access arrive in the same cycle, the flag ends up set.
- R11: `irq` is the OR of `status[5:2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sts_rd | input | 1 | Host reads status word |
| sts_wr | input | 1 | Host writes status word |
| sts_wdata | input | 8 | Status write data (bit 7 = flush request) |
| rxd_rd | input | 1 | Host reads receive data port |
| txd_wr | input | 1 | Host writes transmit data port |
| eng_busy | input | 1 | Master engine busy level |
| eng_arb_lost | input | 1 | Arbitration lost pulse |
| bus_idle | input | 1 | Bus free level |
| eng_addr_nack | input | 1 | Address not acknowledged pulse |
| eng_rx_byte | input | 1 | Byte received pulse |
| eng_tx_done | input | 1 | Transmission finished pulse |
| txf_underflow | input | 1 | Transmit FIFO underflow pulse |
| txf_empty | input | 1 | Transmit FIFO empty level |
| flush_done | input | 1 | FIFO flush finished pulse |
| status | output | 8 | Status word |
| flush_master_tx | output | 1 | Flush request to master transmit FIFO |
| flush_slave_rx | output | 1 | Flush request to slave receive FIFO |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check several rules on every cycle:
- a flag asserted by its set event is set one cycle later;
- a flag that is cleared and not set in the same cycle is clear one cycle later;
- busy follows the engine with one cycle of delay;
- the arbitration flag holds until the bus is idle;
- the flush machine stays in FL_FLUSH until `flush_done` arrives.

Other behaviour can only be shown by the bench's scenarios. These cover which host access clears which flag, and that status writes without bit 7 are ignored. They also cover that `flush_done` outside a flush does nothing, and the rising-edge rule for TX empty.

// File: rtl/i2cm_status_pkg.sv
package i2cm_status_pkg;
    localparam int STS_W    = 8;
    localparam int B_FLUSH  = 7;
    localparam int B_BUSY   = 6;
    localparam int B_ARB    = 5;
    localparam int B_NACK   = 4;
    localparam int B_RXIRQ  = 3;
    localparam int B_TXIRQ  = 2;
    localparam int B_UNDER  = 1;
    localparam int B_EMPTY  = 0;
    localparam int N_STICKY = 7;

    typedef enum logic {
        FL_IDLE  = 1'b0,
        FL_FLUSH = 1'b1
    } flush_state_t;
endpackage

// File: rtl/i2cm_flag_cell.sv
module i2cm_flag_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q_o <= RST_VAL;
        else if (set_i)
            q_o <= 1'b1;
        else if (clr_i)
            q_o <= 1'b0;
    end

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    a_r6_r7_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/i2cm_flush_fsm.sv
module i2cm_flush_fsm
    import i2cm_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic done_i,
    output logic flushing_o
);
    flush_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE:  if (start_i) state_d = FL_FLUSH;
            FL_FLUSH: if (done_i)  state_d = FL_IDLE;
            default:  state_d = FL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        flushing_o = (state_q == FL_FLUSH);
    end

    a_r2_flush_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FL_FLUSH && !done_i) |=> (state_q == FL_FLUSH));
    a_r2_flush_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FL_FLUSH && done_i) |=> (state_q == FL_IDLE));
    a_r2_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FL_IDLE && !start_i) |=> (state_q == FL_IDLE));
endmodule

// File: rtl/i2cm_status.sv
module i2cm_status
    import i2cm_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sts_rd,
    input  logic       sts_wr,
    input  logic [7:0] sts_wdata,
    input  logic       rxd_rd,
    input  logic       txd_wr,
    input  logic       eng_busy,
    input  logic       eng_arb_lost,
    input  logic       bus_idle,
    input  logic       eng_addr_nack,
    input  logic       eng_rx_byte,
    input  logic       eng_tx_done,
    input  logic       txf_underflow,
    input  logic       txf_empty,
    input  logic       flush_done,
    output logic [7:0] status,
    output logic       flush_master_tx,
    output logic       flush_slave_rx,
    output logic       irq
);
    logic                empty_q;
    logic                empty_rise;
    logic                flushing;
    logic [N_STICKY-1:0] set_v;
    logic [N_STICKY-1:0] clr_v;
    logic [N_STICKY-1:0] flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) empty_q <= 1'b1;
        else        empty_q <= txf_empty;
    end

    always_comb begin
        empty_rise = txf_empty & ~empty_q;
        set_v = '0;
        clr_v = '0;
        set_v[B_EMPTY] = empty_rise;     clr_v[B_EMPTY] = txd_wr;
        set_v[B_UNDER] = txf_underflow;  clr_v[B_UNDER] = txd_wr;
        set_v[B_TXIRQ] = eng_tx_done;    clr_v[B_TXIRQ] = txd_wr;
        set_v[B_RXIRQ] = eng_rx_byte;    clr_v[B_RXIRQ] = rxd_rd;
        set_v[B_NACK]  = eng_addr_nack;  clr_v[B_NACK]  = sts_rd;
        set_v[B_ARB]   = eng_arb_lost;   clr_v[B_ARB]   = bus_idle;
        set_v[B_BUSY]  = eng_busy;       clr_v[B_BUSY]  = ~eng_busy;
    end

    for (genvar i = 0; i < N_STICKY; i++) begin : g_flag
        i2cm_flag_cell #(
            .RST_VAL((i == B_EMPTY) ? 1'b1 : 1'b0)
        ) u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .set_i(set_v[i]),
            .clr_i(clr_v[i]),
            .q_o  (flag_q[i])
        );
    end

    i2cm_flush_fsm u_flush (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (sts_wr & sts_wdata[B_FLUSH]),
        .done_i    (flush_done),
        .flushing_o(flushing)
    );

    always_comb begin
        status          = {flushing, flag_q};
        flush_master_tx = flushing;
        flush_slave_rx  = flushing;
        irq             = |status[B_ARB:B_TXIRQ];
    end

    a_r4_busy_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status[B_BUSY] == $past(eng_busy)));
    a_r5_arb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (status[B_ARB] && !bus_idle) |=> status[B_ARB]);
    a_r5_arb_free: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idle && !eng_arb_lost) |=> !status[B_ARB]);
    a_r8_txw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_wr && !eng_tx_done && !txf_underflow) |=> (status[B_TXIRQ:B_UNDER] == 2'b00));
endmodule

// File: tb/i2cm_status_bench.sv
module i2cm_status_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sts_rd = 0, sts_wr = 0, rxd_rd = 0, txd_wr = 0;
    logic [7:0] sts_wdata = 8'h00;
    logic       eng_busy = 0, eng_arb_lost = 0, bus_idle = 0, eng_addr_nack = 0;
    logic       eng_rx_byte = 0, eng_tx_done = 0, txf_underflow = 0;
    logic       txf_empty = 1, flush_done = 0;
    logic [7:0] status;
    logic       flush_master_tx, flush_slave_rx, irq;
    int         checks = 0;
    int         errors = 0;

    always #2.5 clk = ~clk;

    i2cm_status u_i2cm_status (
        .clk(clk), .rst_n(rst_n), .sts_rd(sts_rd), .sts_wr(sts_wr),
        .sts_wdata(sts_wdata), .rxd_rd(rxd_rd), .txd_wr(txd_wr),
        .eng_busy(eng_busy), .eng_arb_lost(eng_arb_lost), .bus_idle(bus_idle),
        .eng_addr_nack(eng_addr_nack), .eng_rx_byte(eng_rx_byte),
        .eng_tx_done(eng_tx_done), .txf_underflow(txf_underflow),
        .txf_empty(txf_empty), .flush_done(flush_done), .status(status),
        .flush_master_tx(flush_master_tx), .flush_slave_rx(flush_slave_rx), .irq(irq)
    );

    localparam logic [13:0] I_RD   = 14'h2000;
    localparam logic [13:0] I_WR   = 14'h1000;
    localparam logic [13:0] I_W7   = 14'h0800;
    localparam logic [13:0] I_RXR  = 14'h0400;
    localparam logic [13:0] I_TXW  = 14'h0200;
    localparam logic [13:0] I_BSY  = 14'h0100;
    localparam logic [13:0] I_ARB  = 14'h0080;
    localparam logic [13:0] I_IDL  = 14'h0040;
    localparam logic [13:0] I_NAK  = 14'h0020;
    localparam logic [13:0] I_RXB  = 14'h0010;
    localparam logic [13:0] I_TXD  = 14'h0008;
    localparam logic [13:0] I_UNF  = 14'h0004;
    localparam logic [13:0] I_EMP  = 14'h0002;
    localparam logic [13:0] I_FDN  = 14'h0001;
    localparam int NV = 22;

    localparam logic [21:0] VEC [NV] = '{
        {I_TXW | I_EMP,         8'h00},  // R9 clear by tx write
        {I_BSY,                 8'h40},  // R4
        {I_BSY | I_NAK,         8'h50},  // R6 set
        {I_BSY | I_RD,          8'h40},  // R6 clear
        {I_RXB,                 8'h08},  // R7 set, R4 busy drop
        {I_RXR,                 8'h00},  // R7 clear
        {I_TXD | I_UNF,         8'h06},  // R8 set
        {I_TXW,                 8'h00},  // R8 clear
        {I_EMP,                 8'h01},  // R9 rising edge
        {I_EMP | I_ARB,         8'h21},  // R5 set
        {I_EMP | I_RD,          8'h21},  // R5 read does not clear
        {I_EMP | I_IDL,         8'h01},  // R5 bus idle clears
        {I_EMP | I_RXB | I_RXR, 8'h09},  // R10 set wins
        {I_EMP | I_RXR,         8'h01},  // R7
        {I_EMP | I_NAK | I_RD,  8'h11},  // R10 set wins
        {I_EMP | I_WR,          8'h11},  // R3 write without bit 7
        {I_EMP | I_RD,          8'h01},  // R6
        {I_EMP | I_WR | I_W7,   8'h81},  // R2 flush start
        {I_EMP,                 8'h81},  // R2 flush held
        {I_EMP | I_FDN,         8'h01},  // R2 flush end
        {I_EMP | I_TXW | I_TXD, 8'h04},  // R10 set wins, R9 clear
        {I_TXW,                 8'h00}   // R8 clear
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [13:0] v);
        sts_rd        = v[13];
        sts_wr        = v[12];
        sts_wdata     = v[11] ? 8'h80 : 8'h7F;
        rxd_rd        = v[10];
        txd_wr        = v[9];
        eng_busy      = v[8];
        eng_arb_lost  = v[7];
        bus_idle      = v[6];
        eng_addr_nack = v[5];
        eng_rx_byte   = v[4];
        eng_tx_done   = v[3];
        txf_underflow = v[2];
        txf_empty     = v[1];
        flush_done    = v[0];
    endtask

    task automatic step(input logic [13:0] v);
        @(negedge clk);
        apply(v);
        @(posedge clk);
        #1;
    endtask

    initial begin
        #100us;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #12;
        check("R1 status", 32'(status), 32'h01);
        check("R1 flush", 32'({flush_master_tx, flush_slave_rx, irq}), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][21:8]);
            check("R2-R10 status", 32'(status), 32'(VEC[i][7:0]));
            check("R11 irq", 32'(irq), 32'(|VEC[i][5:2]));
            check("R2 flush outputs", 32'({flush_master_tx, flush_slave_rx}),
                  32'({VEC[i][7], VEC[i][7]}));
        end

        // R2: flush_done outside a flush does nothing
        step(I_FDN);
        check("R2 stray done", 32'({status[7], flush_master_tx}), 32'h0);
        // R2: a second flush runs and ends
        step(I_WR | I_W7);
        step(14'h0);
        check("R2 flush active", 32'({flush_master_tx, flush_slave_rx}), 32'h3);
        step(I_FDN);
        check("R2 flush cleared", 32'({status[7], flush_slave_rx}), 32'h0);
        // R1: reset mid-run restores defaults
        step(I_NAK | I_ARB | I_BSY);
        check("R11 irq raised", 32'(irq), 32'h1);
        @(negedge clk);
        apply(14'h0);
        rst_n = 1'b0;
        #1;
        check("R1 reset again", 32'(status), 32'h01);
        check("R1 irq low", 32'(irq), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule